// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Hardware Table Walk

The block translates 32-bit virtual addresses into 30-bit physical addresses for 4 KiB pages. The upper 20 bits of a virtual address select a page and the lower 12 bits are the position inside it. That position is copied unchanged into the physical address. Recent mappings are held in a small fully associative store. The number of entries is a parameter that must stay at or below 512.

When a lookup misses, the block reads one page-table entry from a single-level table in main memory. It reads through a request/acknowledge port, at the base pointer plus four times the page number. A fetched entry whose valid bit is set is installed, and the lookup then runs again. A fetched entry whose valid bit is clear ends the access with a page fault. Each installed mapping carries read/write permission bits, a dirty bit and a reference bit. When the store is full, the least recently used mapping is replaced. A flush input drops every mapping at once.

Top module: `vpage_xlate`

## Requirements
- R1: A successful translation returns `resp_paddr` = {physical page, `req_vaddr[11:0]`}, where the physical page is bits 17..0 of the page-table entry for virtual page `req_vaddr[31:12]`.
- R2: A request accepted (`req_valid` and `req_ready` at a rising edge) that hits raises `resp_valid` for the cycle right after that edge, and makes no memory read.
- R3: On a miss, exactly one read is issued, at `mem_addr` = `pt_base` + (page number << 2). `mem_req` stays high with a stable address until `mem_ack` is sampled high.
- R4: A fetched entry with bit 31 set is installed and the access completes. `resp_valid` rises in the second cycle after the cycle in which `mem_ack` is high, and later accesses to that page hit.
- R5: A fetched entry with bit 31 clear gives `resp_valid` with `page_fault`=1 and `resp_paddr`=0 in the cycle after the acknowledge. Nothing is installed, so a repeated access walks again.
- R6: Entry bit 30 allows writes and bit 29 allows reads. An access that lacks its permission gives `prot_fault`=1 and `resp_paddr`=0, and it does not mark the page dirty.
- R7: Every successful translation sets the entry's reference bit. A successful write sets its dirty bit. The dirty state starts from entry bit 28 and is reported after the access on `resp_dirty`.
- R8: An install goes to the lowest-numbered empty slot if one exists. Otherwise it replaces the mapping least recently used by a successful translation.
- R9: A one-cycle `flush` invalidates all mappings, so the next access to any page misses.
- R10: `req_ready` is high only while the block is idle and `flush` is low. After reset it is high, while `resp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all mappings |
| pt_base | input | 30 | Physical byte address of the page table |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a write |
| req_vaddr | input | 32 | Virtual address |
| req_ready | output | 1 | Request can be taken this cycle |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 30 | Physical address, zero on a fault |
| resp_dirty | output | 1 | Dirty state of the page after the access |
| page_fault | output | 1 | Table entry was not valid |
| prot_fault | output | 1 | Access not permitted |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 30 | Table entry byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry |

## Verification
The assertions check, on every cycle, the invariants the logic must keep: at most one mapping matches, the page offset passes through on every successful response, the two fault kinds never appear together, a pending memory read holds its address, a flush empties the store, translated accesses set reference and dirty bits, and the age order always has exactly one oldest entry. Only the bench scenarios can show which mapping the replacement evicts, the exact hit and refill latencies, and that faulting accesses leave no mapping or dirty mark behind. They also show that every address matches the independently computed page table.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_RETRY = 2'd2
  } xl_state_e;

  // Page-table entry field positions
  localparam int PTE_V_BIT  = 31;
  localparam int PTE_WR_BIT = 30;
  localparam int PTE_RD_BIT = 29;
  localparam int PTE_D_BIT  = 28;
endpackage

// File: rtl/vpx_entry_array.sv
module vpx_entry_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [PPN_W-1:0]   hit_ppn,
  output logic [1:0]         hit_perm,
  output logic               hit_dirty,
  input  logic               touch_en,
  input  logic               touch_wr,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic [1:0]         fill_perm,
  input  logic               fill_dirty,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] valid_q, valid_d, dirty_q, dirty_d, ref_q, ref_d, hit_vec;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [VPN_W-1:0]   vpn_d  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_d  [ENTRIES];
  logic [1:0]         perm_q [ENTRIES];
  logic [1:0]         perm_d [ENTRIES];

  // Associative match
  always_comb begin
    hit_idx   = '0;
    hit_ppn   = '0;
    hit_perm  = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i] = valid_q[i] && (vpn_q[i] == lk_vpn);
      if (hit_vec[i]) begin
        hit_idx   = IDX_W'(i);
        hit_ppn   = ppn_q[i];
        hit_perm  = perm_q[i];
        hit_dirty = dirty_q[i];
      end
    end
  end
  assign hit       = |hit_vec;
  assign valid_vec = valid_q;

  // Next state
  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    ref_d   = ref_q;
    for (int i = 0; i < ENTRIES; i++) begin
      vpn_d[i]  = vpn_q[i];
      ppn_d[i]  = ppn_q[i];
      perm_d[i] = perm_q[i];
    end
    if (fill_en) begin
      valid_d[fill_idx] = 1'b1;
      vpn_d[fill_idx]   = fill_vpn;
      ppn_d[fill_idx]   = fill_ppn;
      perm_d[fill_idx]  = fill_perm;
      dirty_d[fill_idx] = fill_dirty;
      ref_d[fill_idx]   = 1'b0;
    end
    if (touch_en) begin
      ref_d[hit_idx] = 1'b1;
      if (touch_wr) dirty_d[hit_idx] = 1'b1;
    end
    if (flush) valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        ppn_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
      ref_q   <= ref_d;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= vpn_d[i];
        ppn_q[i]  <= ppn_d[i];
        perm_q[i] <= perm_d[i];
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0)); // R9
  AST_TOUCH_REFS: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> ref_q[$past(hit_idx)]); // R7
  AST_WRITE_DIRTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && touch_wr) |=> dirty_q[$past(hit_idx)]); // R7
endmodule

// File: rtl/vpx_lru_age.sv
module vpx_lru_age #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0]   age_q [ENTRIES];
  logic [IDX_W-1:0]   age_d [ENTRIES];
  logic [ENTRIES-1:0] oldest_vec;

  // Age 0 is most recent; ages always form a permutation of 0..ENTRIES-1
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (IDX_W'(i) == touch_idx)           age_d[i] = '0;
        else if (age_q[i] < age_q[touch_idx]) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      oldest_vec[i] = (age_q[i] == IDX_W'(ENTRIES - 1));
      if (oldest_vec[i]) victim_idx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) victim_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= age_d[i];
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1); // R8
endmodule

// File: rtl/vpx_walk_ctrl.sv
module vpx_walk_ctrl
  import vpx_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFS_W = 12,
  parameter int PTE_W = 32,
  parameter int VPN_W = VA_W - OFS_W,
  parameter int PPN_W = PA_W - OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PA_W-1:0]  pt_base,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_dirty,
  output logic             page_fault,
  output logic             prot_fault,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic [VPN_W-1:0] lk_vpn,
  input  logic             hit,
  input  logic [PPN_W-1:0] hit_ppn,
  input  logic [1:0]       hit_perm,
  input  logic             hit_dirty,
  output logic             touch_en,
  output logic             touch_wr,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PPN_W-1:0] fill_ppn,
  output logic [1:0]       fill_perm,
  output logic             fill_dirty
);
  xl_state_e        st_q, st_d;
  logic [VA_W-1:0]  vaddr_q, cur_va;
  logic             wr_q, cur_wr, accept, lookup, perm_ok;
  logic             rv_d, pf_d, prf_d, dty_d;
  logic [PA_W-1:0]  pa_d;
  logic             unused_pte_bits;

  assign req_ready = (st_q == ST_IDLE) && !flush;
  assign accept    = req_ready && req_valid;
  assign lookup    = accept || (st_q == ST_RETRY);
  assign cur_va    = (st_q == ST_IDLE) ? req_vaddr : vaddr_q;
  assign cur_wr    = (st_q == ST_IDLE) ? req_write : wr_q;
  assign lk_vpn    = cur_va[VA_W-1:OFS_W];
  assign perm_ok   = cur_wr ? hit_perm[1] : hit_perm[0];
  assign touch_wr  = cur_wr;

  assign mem_addr   = pt_base + PA_W'({vaddr_q[VA_W-1:OFS_W], 2'b00});
  assign fill_vpn   = vaddr_q[VA_W-1:OFS_W];
  assign fill_ppn   = mem_rdata[PPN_W-1:0];
  assign fill_perm  = {mem_rdata[PTE_WR_BIT], mem_rdata[PTE_RD_BIT]};
  assign fill_dirty = mem_rdata[PTE_D_BIT];
  assign unused_pte_bits = ^mem_rdata[PTE_D_BIT-1:PPN_W];

  always_comb begin
    st_d     = st_q;
    rv_d     = 1'b0;
    pf_d     = 1'b0;
    prf_d    = 1'b0;
    dty_d    = 1'b0;
    pa_d     = '0;
    touch_en = 1'b0;
    fill_en  = 1'b0;
    mem_req  = 1'b0;
    if (lookup) begin
      if (hit) begin
        rv_d = 1'b1;
        st_d = ST_IDLE;
        if (perm_ok) begin
          pa_d     = {hit_ppn, cur_va[OFS_W-1:0]};
          dty_d    = hit_dirty | cur_wr;
          touch_en = 1'b1;
        end else begin
          prf_d = 1'b1;
        end
      end else begin
        st_d = ST_WALK;
      end
    end
    if (st_q == ST_WALK) begin
      mem_req = 1'b1;
      if (mem_ack) begin
        if (mem_rdata[PTE_V_BIT]) begin
          fill_en = 1'b1;
          st_d    = ST_RETRY;
        end else begin
          rv_d = 1'b1;
          pf_d = 1'b1;
          st_d = ST_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_paddr <= '0;
      resp_dirty <= 1'b0;
      page_fault <= 1'b0;
      prot_fault <= 1'b0;
      vaddr_q    <= '0;
      wr_q       <= 1'b0;
    end else begin
      st_q       <= st_d;
      resp_valid <= rv_d;
      resp_paddr <= pa_d;
      resp_dirty <= dty_d;
      page_fault <= pf_d;
      prot_fault <= prf_d;
      if (accept) begin
        vaddr_q <= req_vaddr;
        wr_q    <= req_write;
      end
    end
  end

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !page_fault && !prot_fault) |->
      (resp_paddr[OFS_W-1:0] == vaddr_q[OFS_W-1:0])); // R1
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R3
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (page_fault || prot_fault)) |-> (resp_paddr == '0)); // R5
  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_fault && prot_fault)); // R6
endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int OFS_W   = 12,
  parameter int PTE_W   = 32,
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PA_W-1:0]  pt_base,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_dirty,
  output logic             page_fault,
  output logic             prot_fault,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]   lk_vpn, fill_vpn;
  logic [PPN_W-1:0]   hit_ppn, fill_ppn;
  logic [1:0]         hit_perm, fill_perm;
  logic [IDX_W-1:0]   hit_idx, victim_idx;
  logic [ENTRIES-1:0] valid_vec;
  logic               hit, hit_dirty, touch_en, touch_wr, fill_en, fill_dirty;

  vpx_walk_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .PTE_W(PTE_W),
    .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
    .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_dirty(resp_dirty), .page_fault(page_fault), .prot_fault(prot_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .lk_vpn(lk_vpn), .hit(hit), .hit_ppn(hit_ppn),
    .hit_perm(hit_perm), .hit_dirty(hit_dirty), .touch_en(touch_en),
    .touch_wr(touch_wr), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm), .fill_dirty(fill_dirty)
  );

  vpx_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vpn(lk_vpn), .hit(hit),
    .hit_idx(hit_idx), .hit_ppn(hit_ppn), .hit_perm(hit_perm),
    .hit_dirty(hit_dirty), .touch_en(touch_en), .touch_wr(touch_wr),
    .fill_en(fill_en), .fill_idx(victim_idx), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm), .fill_dirty(fill_dirty),
    .valid_vec(valid_vec)
  );

  vpx_lru_age #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(hit_idx),
    .valid_vec(valid_vec), .victim_idx(victim_idx)
  );
endmodule

// File: tb/vpage_xlate_bench.sv
module vpage_xlate_bench;
  localparam int N_ENT   = 4;
  localparam int MEM_DLY = 2;
  localparam logic [29:0] BASE = 30'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        req_ready, resp_valid, resp_dirty, page_fault, prot_fault, mem_req;
  logic [29:0] resp_paddr, mem_addr;

  int n_chk = 0, n_bad = 0, reads = 0, dly = 0;
  logic [29:0] last_addr = '0;
  int got_cyc, got_rd;
  logic [29:0] got_pa;
  logic got_pf, got_prf, got_dty;

  always #10 clk = ~clk;  // 50 MHz

  vpage_xlate #(.ENTRIES(N_ENT)) u_vpage_xlate (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(BASE),
    .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_dirty(resp_dirty), .page_fault(page_fault), .prot_fault(prot_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // Page table model: valid bit 31, write-ok 30, read-ok 29, dirty 28, ppn 17..0
  function automatic logic [17:0] ppn_of(logic [19:0] vpn);
    return vpn[17:0] ^ 18'h2A5A5;
  endfunction
  function automatic logic [31:0] pte_of(logic [19:0] vpn);
    logic [1:0] perm;
    if (vpn == 20'h0BAD0) return 32'h0;
    perm = (vpn == 20'h00777) ? 2'b01 : (vpn == 20'h00555) ? 2'b10 : 2'b11;
    return {1'b1, perm, (vpn == 20'h00333), 10'b0, ppn_of(vpn)};
  endfunction
  function automatic logic [29:0] pa_of(logic [31:0] va);
    return {ppn_of(va[31:12]), va[11:0]};
  endfunction

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (dly == MEM_DLY) begin
        mem_ack   = 1'b1;
        last_addr = mem_addr;
        mem_rdata = pte_of(20'((mem_addr - BASE) >> 2));
        reads++;
        dly = 0;
      end else dly++;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] va);
    int n = 0;
    int rd0 = reads;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && n < 64) begin
      @(negedge clk);
      n++;
    end
    got_cyc = n; got_pa = resp_paddr; got_pf = page_fault;
    got_prf = prot_fault; got_dty = resp_dirty; got_rd = reads - rd0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk("R10", "ready low during flush", 32'(req_ready), 0);
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "ready after reset", 32'(req_ready), 1);
    chk("R10", "no response after reset", 32'(resp_valid), 0);
    chk("R10", "no walk after reset", 32'(mem_req), 0);
  endtask

  task automatic t_miss_then_hit();
    access(1'b0, 32'h0001_2345);
    chk("R3", "one table read", 32'(got_rd), 1);
    chk("R3", "entry address", 32'(last_addr), 32'(BASE + 30'h48));
    chk("R1", "refill paddr", 32'(got_pa), 32'(pa_of(32'h0001_2345)));
    chk("R4", "refill latency", 32'(got_cyc), 4);
    chk("R7", "clean after read", 32'(got_dty), 0);
    access(1'b0, 32'h0001_2FF0);
    chk("R2", "hit latency", 32'(got_cyc), 0);
    chk("R2", "hit makes no read", 32'(got_rd), 0);
    chk("R1", "hit paddr", 32'(got_pa), 32'(pa_of(32'h0001_2FF0)));
  endtask

  task automatic t_dirty();
    access(1'b1, 32'h0001_2ABC);
    chk("R7", "dirty after write", 32'(got_dty), 1);
    access(1'b0, 32'h0001_2000);
    chk("R7", "dirty stays on read", 32'(got_dty), 1);
    access(1'b0, 32'h0033_3010);
    chk("R7", "dirty from table entry", 32'(got_dty), 1);
  endtask

  task automatic t_page_fault();
    access(1'b0, 32'h0BAD_0010);
    chk("R5", "page fault flag", 32'(got_pf), 1);
    chk("R5", "fault paddr zero", 32'(got_pa), 0);
    chk("R5", "fault latency", 32'(got_cyc), 3);
    access(1'b0, 32'h0BAD_0020);
    chk("R5", "walks again", 32'(got_rd), 1);
    chk("R5", "faults again", 32'(got_pf), 1);
  endtask

  task automatic t_protection();
    access(1'b1, 32'h0077_7004);
    chk("R6", "write to read-only", 32'(got_prf), 1);
    chk("R6", "prot paddr zero", 32'(got_pa), 0);
    access(1'b0, 32'h0077_7008);
    chk("R6", "read allowed", 32'(got_prf), 0);
    chk("R6", "denied write left clean", 32'(got_dty), 0);
    chk("R1", "read-only paddr", 32'(got_pa), 32'(pa_of(32'h0077_7008)));
    access(1'b0, 32'h0055_5000);
    chk("R6", "read of write-only", 32'(got_prf), 1);
  endtask

  task automatic t_flush();
    do_flush();
    access(1'b0, 32'h0001_2345);
    chk("R9", "miss after flush", 32'(got_rd), 1);
    chk("R1", "paddr after flush", 32'(got_pa), 32'(pa_of(32'h0001_2345)));
  endtask

  task automatic t_lru();
    do_flush();
    for (int p = 1; p <= 4; p++) access(1'b0, {20'(p), 12'h0});
    for (int p = 1; p <= 4; p++) begin
      access(1'b0, {20'(p), 12'h4});
      chk("R8", "fills used empty slots", 32'(got_rd), 0);
    end
    // recency now 4,3,2,1 (1 oldest); touch 1 so 2 becomes oldest
    access(1'b0, 32'h0000_1008);
    access(1'b0, 32'h0000_5000);
    chk("R8", "new page walked", 32'(got_rd), 1);
    access(1'b0, 32'h0000_1000);
    chk("R8", "recent page kept", 32'(got_rd), 0);
    access(1'b0, 32'h0000_2000);
    chk("R8", "oldest page evicted", 32'(got_rd), 1);
    access(1'b0, 32'h0000_4000);
    chk("R8", "younger page kept", 32'(got_rd), 0);
    access(1'b0, 32'h0000_3000);
    chk("R8", "next oldest evicted", 32'(got_rd), 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_then_hit();
    t_dirty();
    t_page_fault();
    t_protection();
    t_flush();
    t_lru();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule